// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block folds four reset triggers into a single system reset and times a settling window before the core is allowed to run. The triggers are power-on, an external active-low reset pin, a brown-out comparator and a watchdog timeout. While reset is active the core is halted, every memory-mapped register is held at its default by the system reset output, and the I/O pins are forced to high-impedance inputs. Analog detection and oscillator circuits sit outside the block, which sees only their digitized flags.

Each source has its own rule. Power-on is tied to the rising supply-good flag. The pin must stay low for a minimum number of cycles to count, and its sequence starts only when it returns high. Brown-out acts only when its enable bit is set: it holds reset while the supply is low, and it starts its sequence once the supply recovers. A watchdog pulse starts a sequence at once. Every source has its own duration parameter in clock cycles. A new trigger during a running sequence starts the count again with the new source's duration. A one-hot cause register records the most recent source. Only power-on reloads it to its power-on value.

Top module: `sys_reset_seq`

## Requirements
- R1: While `supply_ok` is low, `sys_rst_n` is 0, `core_halt` is 1 and `rst_cause` is 4'b0001. A fall of `supply_ok` asserts reset without waiting for a clock edge. After `supply_ok` rises, `sys_rst_n` returns to 1 exactly 2+POR_CYC clock edges later.
- R2: A low pulse on `ext_rst_n` that lasts fewer than PIN_MIN_CYC clock cycles is ignored. `sys_rst_n` stays 1 and `rst_cause` is unchanged.
- R3: A low pulse of at least PIN_MIN_CYC cycles is a valid pin reset. Reset is held while the pin stays low beyond the minimum. The sequence starts on the return high, and `sys_rst_n` returns to 1 exactly 3+PIN_CYC edges after the pin rises. `rst_cause` becomes 4'b0010.
- R4: While the synchronized pin is low, `analog_lp_req` and `io_tristate` are 1. `analog_lp_req` is 0 once the pin is high.
- R5: With `bor_en` set, a high `bor_low` holds reset. `sys_rst_n` returns to 1 exactly 2+BOR_CYC edges after `bor_low` falls, and `rst_cause` becomes 4'b0100.
- R6: With `bor_en` clear, `bor_low` has no effect on `sys_rst_n` or `rst_cause`.
- R7: A one-cycle `wdt_expire` pulse asserts reset from the next edge for exactly WDT_CYC cycles, and `rst_cause` becomes 4'b1000.
- R8: A trigger that arrives while a sequence is running restarts the count from zero with the new source's duration, and updates `rst_cause` to that source.
- R9: `core_halt` and `io_tristate` are 1 for the whole time `sys_rst_n` is 0.
- R10: `rst_cause` is always one-hot. The bit order is power-on bit 0, pin bit 1, brown-out bit 2, watchdog bit 3. When triggers arrive in the same cycle, brown-out wins over pin, and pin wins over watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| supply_ok | input | 1 | Supply-good flag from the power-on detector, asynchronous, active high |
| bor_low | input | 1 | Supply below brown-out threshold, asynchronous |
| bor_en | input | 1 | Brown-out reset enable bit |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdt_expire | input | 1 | Watchdog timeout pulse, synchronous to clk |
| sys_rst_n | output | 1 | System reset to all registers, active low |
| core_halt | output | 1 | Halts core execution |
| analog_lp_req | output | 1 | Low-power request to the oscillator and analog circuits |
| io_tristate | output | 1 | Forces all I/O to high-impedance input |
| rst_cause | output | 4 | One-hot cause of the most recent reset |

## Verification
The assertions check on every cycle that the cause stays one-hot and that a brown-out hold or a qualified pin hold puts the block in reset on the next cycle. They also check that an unqualified pin rise never starts a sequence, that a watchdog pulse restarts the count with the watchdog cause, and that a release happens only at the last count of the selected duration. Only the bench scenarios can show the absolute release latencies for each source. The same holds for the qualification boundary, swept across pulse widths around PIN_MIN_CYC, for restarts at every offset inside a running sequence, and for the asynchronous assertion on a supply drop.

// File: rtl/sys_reset_seq.sv
module sys_reset_seq #(
  parameter int POR_CYC     = 20,
  parameter int PIN_CYC     = 12,
  parameter int BOR_CYC     = 16,
  parameter int WDT_CYC     = 8,
  parameter int PIN_MIN_CYC = 5
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       bor_low,
  input  logic       bor_en,
  input  logic       ext_rst_n,
  input  logic       wdt_expire,
  output logic       sys_rst_n,
  output logic       core_halt,
  output logic       analog_lp_req,
  output logic       io_tristate,
  output logic [3:0] rst_cause
);

  localparam int MAX_A = (POR_CYC > PIN_CYC) ? POR_CYC : PIN_CYC;
  localparam int MAX_B = (BOR_CYC > WDT_CYC) ? BOR_CYC : WDT_CYC;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_D + 1);
  localparam int LOW_W = $clog2(PIN_MIN_CYC + 1);

  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYC - 1);
  localparam logic [CNT_W-1:0] PIN_LAST = CNT_W'(PIN_CYC - 1);
  localparam logic [CNT_W-1:0] BOR_LAST = CNT_W'(BOR_CYC - 1);
  localparam logic [CNT_W-1:0] WDT_LAST = CNT_W'(WDT_CYC - 1);
  localparam logic [LOW_W-1:0] LOW_MIN  = LOW_W'(PIN_MIN_CYC);

  localparam logic [3:0] SRC_POR = 4'b0001;
  localparam logic [3:0] SRC_PIN = 4'b0010;
  localparam logic [3:0] SRC_BOR = 4'b0100;
  localparam logic [3:0] SRC_WDT = 4'b1000;

  logic [1:0]       por_sync;
  logic [1:0]       pin_sync;
  logic [1:0]       bor_sync;
  logic [LOW_W-1:0] lowcnt;
  logic             active;
  logic [3:0]       src;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dur_last;
  logic [3:0]       new_src;
  logic             trig;

  always_ff @(posedge clk or negedge supply_ok)
    if (!supply_ok) por_sync <= 2'b00;
    else            por_sync <= {por_sync[0], 1'b1};

  wire por_ok = por_sync[1];

  always_ff @(posedge clk or negedge por_ok)
    if (!por_ok) begin
      pin_sync <= 2'b11;
      bor_sync <= 2'b00;
    end else begin
      pin_sync <= {pin_sync[0], ext_rst_n};
      bor_sync <= {bor_sync[0], bor_low};
    end

  wire pin_s    = pin_sync[1];
  wire bor_s    = bor_sync[1];
  wire pin_qual = (lowcnt == LOW_MIN);
  wire pin_hold = !pin_s && pin_qual;
  wire pin_rise = pin_s && pin_qual;
  wire bor_hold = bor_en && bor_s;

  always_ff @(posedge clk or negedge por_ok)
    if (!por_ok)     lowcnt <= '0;
    else if (pin_s)  lowcnt <= '0;
    else if (!pin_qual) lowcnt <= lowcnt + 1'b1;

  always_comb begin
    trig    = 1'b1;
    new_src = SRC_WDT;
    if (bor_hold)                  new_src = SRC_BOR;
    else if (pin_hold || pin_rise) new_src = SRC_PIN;
    else if (wdt_expire)           new_src = SRC_WDT;
    else                           trig    = 1'b0;
  end

  always_comb
    case (src)
      SRC_PIN: dur_last = PIN_LAST;
      SRC_BOR: dur_last = BOR_LAST;
      SRC_WDT: dur_last = WDT_LAST;
      default: dur_last = POR_LAST;
    endcase

  always_ff @(posedge clk or negedge por_ok)
    if (!por_ok) begin
      active    <= 1'b1;
      src       <= SRC_POR;
      cnt       <= '0;
      rst_cause <= SRC_POR;
    end else if (trig) begin
      active    <= 1'b1;
      src       <= new_src;
      cnt       <= '0;
      rst_cause <= new_src;
    end else if (active) begin
      if (cnt == dur_last) active <= 1'b0;
      else                 cnt    <= cnt + 1'b1;
    end

  assign sys_rst_n     = !active;
  assign core_halt     = active;
  assign analog_lp_req = !pin_s;
  assign io_tristate   = active || !pin_s;

  p_cause_onehot_r10: assert property (@(posedge clk) disable iff (!por_ok)
    $countones(rst_cause) == 1);

  p_bor_hold_r5: assert property (@(posedge clk) disable iff (!por_ok)
    bor_hold |=> (!sys_rst_n && rst_cause == SRC_BOR));

  p_pin_hold_r3: assert property (@(posedge clk) disable iff (!por_ok)
    (pin_hold && !bor_hold) |=> (!sys_rst_n && rst_cause == SRC_PIN));

  p_short_pin_r2: assert property (@(posedge clk) disable iff (!por_ok)
    (pin_s && lowcnt != '0 && !pin_qual && !bor_hold && !wdt_expire && !active)
      |=> sys_rst_n);

  p_wdt_restart_r7: assert property (@(posedge clk) disable iff (!por_ok)
    (wdt_expire && !bor_hold && !pin_hold && !pin_rise)
      |=> (!sys_rst_n && rst_cause == SRC_WDT && cnt == '0));

  p_release_r8: assert property (@(posedge clk) disable iff (!por_ok)
    $rose(sys_rst_n) |-> ($past(cnt) == $past(dur_last)));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!por_ok)
    active |-> (cnt <= dur_last));

endmodule

// File: tb/sys_reset_seq_tb_top.sv
`timescale 1ns/1ps
module sys_reset_seq_tb_top;

  localparam int POR_CYC = 20;
  localparam int PIN_CYC = 12;
  localparam int BOR_CYC = 16;
  localparam int WDT_CYC = 8;
  localparam int PIN_MIN = 5;

  logic clk = 1'b0;
  logic supply_ok, bor_low, bor_en, ext_rst_n, wdt_expire;
  logic sys_rst_n, core_halt, analog_lp_req, io_tristate;
  logic [3:0] rst_cause;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sys_reset_seq #(
    .POR_CYC(POR_CYC), .PIN_CYC(PIN_CYC), .BOR_CYC(BOR_CYC),
    .WDT_CYC(WDT_CYC), .PIN_MIN_CYC(PIN_MIN)
  ) dut_i (
    .clk(clk), .supply_ok(supply_ok), .bor_low(bor_low), .bor_en(bor_en),
    .ext_rst_n(ext_rst_n), .wdt_expire(wdt_expire), .sys_rst_n(sys_rst_n),
    .core_halt(core_halt), .analog_lp_req(analog_lp_req),
    .io_tristate(io_tristate), .rst_cause(rst_cause)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  bit halt_bad = 1'b0;
  always @(negedge clk)
    if (supply_ok && !sys_rst_n && !(core_halt && io_tristate)) halt_bad = 1'b1;

  task automatic wait_release(input int limit, output int n, output bit seen);
    n = 0;
    seen = 1'b0;
    while (!(seen && sys_rst_n) && n < limit) begin
      @(negedge clk);
      n++;
      if (!sys_rst_n) seen = 1'b1;
    end
  endtask

  task automatic pulse_wdt();
    wdt_expire = 1'b1;
    @(negedge clk);
    wdt_expire = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    bit bor_bad;
    supply_ok = 0; bor_low = 0; bor_en = 0; ext_rst_n = 1; wdt_expire = 0;
    repeat (3) @(negedge clk);

    check(sys_rst_n == 0, "R1 reset held", sys_rst_n, 0);
    check(core_halt == 1, "R1 halt held", core_halt, 1);
    check(rst_cause == 4'b0001, "R1 cause", rst_cause, 1);
    supply_ok = 1;
    wait_release(400, n, seen);
    check(seen && n == 2 + POR_CYC, "R1 por release", n, 2 + POR_CYC);
    check(rst_cause == 4'b0001, "R1 cause after", rst_cause, 1);
    repeat (3) @(negedge clk);

    for (int len = 1; len <= PIN_MIN + 3; len++) begin
      ext_rst_n = 0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (i == 1) begin
          check(analog_lp_req == 1, "R4 lp_req while low", analog_lp_req, 1);
          check(io_tristate == 1, "R4 tristate while low", io_tristate, 1);
        end
      end
      ext_rst_n = 1;
      if (len >= PIN_MIN) begin
        wait_release(400, n, seen);
        check(seen && n == 3 + PIN_CYC, "R3 pin release", n, 3 + PIN_CYC);
        check(rst_cause == 4'b0010, "R3 pin cause", rst_cause, 2);
      end else begin
        wait_release(3 + PIN_CYC + 6, n, seen);
        check(!seen, "R2 short pulse ignored", seen, 0);
        check(rst_cause == 4'b0001, "R2 cause unchanged", rst_cause, 1);
      end
      check(analog_lp_req == 0, "R4 lp_req released", analog_lp_req, 0);
      repeat (4) @(negedge clk);
    end

    bor_en = 0;
    bor_low = 1;
    bor_bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (!sys_rst_n) bor_bad = 1;
    end
    bor_low = 0;
    repeat (4) @(negedge clk);
    check(!bor_bad, "R6 disabled no reset", bor_bad, 0);
    check(rst_cause == 4'b0010, "R6 cause unchanged", rst_cause, 2);

    bor_en = 1;
    for (int len = 1; len <= 6; len++) begin
      bor_low = 1;
      repeat (len) @(negedge clk);
      bor_low = 0;
      wait_release(400, n, seen);
      check(seen && n == 2 + BOR_CYC, "R5 bor release", n, 2 + BOR_CYC);
      check(rst_cause == 4'b0100, "R5 bor cause", rst_cause, 4);
      repeat (3) @(negedge clk);
    end

    pulse_wdt();
    check(sys_rst_n == 0, "R7 wdt immediate", sys_rst_n, 0);
    wait_release(400, n, seen);
    check(seen && n == WDT_CYC, "R7 wdt length", n, WDT_CYC);
    check(rst_cause == 4'b1000, "R7 wdt cause", rst_cause, 8);
    repeat (3) @(negedge clk);

    for (int k = 1; k < WDT_CYC; k++) begin
      pulse_wdt();
      repeat (k) @(negedge clk);
      pulse_wdt();
      wait_release(400, n, seen);
      check(seen && n == WDT_CYC, "R8 wdt restart", n, WDT_CYC);
      repeat (3) @(negedge clk);
    end

    bor_low = 1;
    repeat (3) @(negedge clk);
    bor_low = 0;
    repeat (4) @(negedge clk);
    pulse_wdt();
    wait_release(400, n, seen);
    check(seen && n == WDT_CYC, "R8 cross-source restart", n, WDT_CYC);
    check(rst_cause == 4'b1000, "R8 cross-source cause", rst_cause, 8);
    repeat (3) @(negedge clk);

    supply_ok = 0;
    #1;
    check(sys_rst_n == 0, "R1 async assert", sys_rst_n, 0);
    check(rst_cause == 4'b0001, "R1 cause reload", rst_cause, 1);
    @(negedge clk);
    supply_ok = 1;
    wait_release(400, n, seen);
    check(seen && n == 2 + POR_CYC, "R1 por re-release", n, 2 + POR_CYC);

    check(!halt_bad, "R9 halt and tristate during reset", halt_bad, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule